// File: doc/BRIEF.md
# Programmable Chip-Select and Strobe Generator

This block sits on a local bus and turns each bus cycle into select activity for memories and peripherals. Software programs eight decode regions through a small register write port. Each region has a base, a power-of-two size, read and write enables, a data-width bit and four timing values. On a cycle-start pulse the latched address is matched against the regions. The lowest-numbered region that allows the access type wins, and a cycle then runs for that region.

While a cycle runs, eight active-low strobe outputs follow their own configuration. Each strobe picks one region and an access qualifier. It then acts either as a plain chip-select for the whole cycle or as a strobe timed by the region's assert and deassert offsets. READY is returned after the region's wait-state count, and is repeated for each beat of a burst until end-of-burst. After the cycle ends, the block holds off a new cycle to the same region for the region's recovery count and shows this on a busy output. A cycle to any other region may start at once.

Register map (cfg_addr_i, 5 bits). When bit 4 is 0 the write goes to region cfg_addr_i[3:1]. Word 0 (bit 0 = 0) holds base = wdata[31:16], size exponent = wdata[4:0] (size is 64 KB << exponent), read enable = wdata[8], write enable = wdata[9] and wide = wdata[10]. Word 1 (bit 0 = 1) holds assert offset = wdata[7:0], deassert offset = wdata[15:8], READY delay = wdata[23:16] and recovery count = wdata[31:24]. When cfg_addr_i[4:3] = 2'b10 the write goes to strobe cfg_addr_i[2:0], with region select = wdata[2:0], qualifier = wdata[5:4] (bit 4 allows reads, bit 5 allows writes) and synchronous mode = wdata[8].

Top module: `cs_strobe_gen`

## Requirements
- R1: After reset all strobes are high, and ready_o, hit_o, busy_o and region_wide_o are low. All regions are disabled.
- R2: A region matches when (addr[31:16] XOR base) masked by ~((1 << size exponent) - 1) is zero. The cycle starts on the clock edge that samples cyc_start_i, and hit_o is high from that edge until the cycle ends.
- R3: When several regions match, the lowest-numbered one runs the cycle.
- R4: A read only matches regions whose read enable is set, and a write only matches regions whose write enable is set.
- R5: An asynchronous strobe whose selected region runs the cycle, and whose qualifier allows the access, is low for every clock of the cycle.
- R6: A synchronous strobe is low only in clocks k with assert <= k < deassert, where k = 0 is the first clock of the cycle.
- R7: A strobe whose qualifier bit for the current access type is clear stays high.
- R8: ready_o is high in clock k = READY delay, and again READY delay + 1 clocks after each ready_o within a burst.
- R9: A ready_o with last_i high ends the cycle: hit_o and all strobes go inactive on the next clock.
- R10: After a cycle ends, busy_o is high for exactly the recovery count of clocks. A start to the same region during that time is held and its cycle begins in the clock after busy_o falls.
- R11: A start to a different region during recovery begins its cycle on the next clock.
- R12: During a cycle, region_wide_o shows the width bit of the running region.
- R13: A start that matches no region produces no hit, no strobe and no ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 5 | Register word address |
| cfg_wdata_i | input | 32 | Register write data |
| cyc_start_i | input | 1 | Bus cycle start pulse |
| addr_i | input | 32 | Latched cycle address |
| wr_i | input | 1 | 1 = write, 0 = read |
| last_i | input | 1 | End-of-burst, qualifies ready_o |
| strobe_no | output | 8 | Active-low strobes |
| ready_o | output | 1 | Wait-state READY pulse |
| hit_o | output | 1 | A region cycle is running |
| busy_o | output | 1 | Recovery hold-off in progress |
| region_wide_o | output | 1 | Width bit of the running region |

## Verification
The start pulse is sampled on one edge, and the cycle's first clock (k = 0) is the following half period. Hit, strobes, READY and width are therefore checked at every falling edge from then on against a clock index the bench keeps itself. READY is due READY delay clocks after cycle start, and again READY delay + 1 clocks after each READY. Hit and strobes are due to drop in the sample after the last READY. busy_o is sampled for exactly the recovery count of falling edges after that, and must be low at the next one. A held same-region start must show its k = 0 in that same sample, while a start to another region shows k = 0 one sample after it is driven.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int ADDR_W    = 32;
  localparam int GRAN_W    = 16;
  localparam int HI_W      = ADDR_W - GRAN_W;
  localparam int SZ_W      = 5;
  localparam int CNT_W     = 8;
  localparam int N_REG     = 8;
  localparam int N_STB     = 8;
  localparam int REG_IDX_W = $clog2(N_REG);
  localparam int STB_IDX_W = $clog2(N_STB);
  localparam int CFG_AW    = 5;
  localparam int CFG_DW    = 32;

  typedef enum logic [1:0] {
    QUAL_NONE = 2'b00,
    QUAL_RD   = 2'b01,
    QUAL_WR   = 2'b10,
    QUAL_BOTH = 2'b11
  } qual_e;

  typedef struct packed {
    logic [HI_W-1:0] base;
    logic [SZ_W-1:0] sz;
    logic            rd_en;
    logic            wr_en;
  } region_cfg_t;

  typedef struct packed {
    logic [CNT_W-1:0] b2b;
    logic [CNT_W-1:0] rdy;
    logic [CNT_W-1:0] deas;
    logic [CNT_W-1:0] asrt;
  } region_tim_t;

  typedef struct packed {
    logic [REG_IDX_W-1:0] sel;
    qual_e                qual;
    logic                 sync;
  } strobe_cfg_t;
endpackage

// File: rtl/cs_region_file.sv
module cs_region_file
  import cs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CFG_AW-1:0] addr_i,
  input  logic [CFG_DW-1:0] wdata_i,
  output region_cfg_t       cfg_o  [N_REG],
  output region_tim_t       tim_o  [N_REG],
  output logic [N_REG-1:0]  wide_o,
  output strobe_cfg_t       scfg_o [N_STB]
);
  logic reg_space, stb_space;
  assign reg_space = we_i && !addr_i[4];
  assign stb_space = we_i && (addr_i[4:3] == 2'b10);

  for (genvar r = 0; r < N_REG; r++) begin : g_reg
    logic sel_r;
    assign sel_r = reg_space && (addr_i[3:1] == r[2:0]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_o[r]  <= '0;
        tim_o[r]  <= '0;
        wide_o[r] <= 1'b0;
      end else if (sel_r && !addr_i[0]) begin
        cfg_o[r].base  <= wdata_i[31:16];
        cfg_o[r].sz    <= wdata_i[4:0];
        cfg_o[r].rd_en <= wdata_i[8];
        cfg_o[r].wr_en <= wdata_i[9];
        wide_o[r]      <= wdata_i[10];
      end else if (sel_r && addr_i[0]) begin
        tim_o[r].asrt <= wdata_i[7:0];
        tim_o[r].deas <= wdata_i[15:8];
        tim_o[r].rdy  <= wdata_i[23:16];
        tim_o[r].b2b  <= wdata_i[31:24];
      end
    end
  end

  for (genvar s = 0; s < N_STB; s++) begin : g_stb
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        scfg_o[s] <= '{sel: '0, qual: QUAL_NONE, sync: 1'b0};
      end else if (stb_space && (addr_i[2:0] == s[2:0])) begin
        scfg_o[s].sel  <= wdata_i[REG_IDX_W-1:0];
        scfg_o[s].qual <= qual_e'(wdata_i[5:4]);
        scfg_o[s].sync <= wdata_i[8];
      end
    end
  end
endmodule

// File: rtl/cs_addr_match.sv
module cs_addr_match
  import cs_pkg::*;
(
  input  region_cfg_t          cfg_i [N_REG],
  input  logic [HI_W-1:0]      addr_hi_i,
  input  logic                 wr_i,
  output logic                 hit_o,
  output logic [REG_IDX_W-1:0] idx_o
);
  logic [N_REG-1:0] hit_v;

  for (genvar r = 0; r < N_REG; r++) begin : g_cmp
    logic [HI_W-1:0] mask;
    logic            type_ok;
    assign mask     = {HI_W{1'b1}} << cfg_i[r].sz;
    assign type_ok  = wr_i ? cfg_i[r].wr_en : cfg_i[r].rd_en;
    assign hit_v[r] = type_ok && (((addr_hi_i ^ cfg_i[r].base) & mask) == '0);
  end

  // lowest index wins
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int r = N_REG - 1; r >= 0; r--) begin
      if (hit_v[r]) begin
        hit_o = 1'b1;
        idx_o = r[REG_IDX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/cs_cycle_fsm.sv
module cs_cycle_fsm
  import cs_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 hit_i,
  input  logic [REG_IDX_W-1:0] idx_i,
  input  logic                 wr_i,
  input  logic                 last_i,
  input  logic [CNT_W-1:0]     rdy_dly_i,
  input  logic [CNT_W-1:0]     b2b_dly_i,
  output logic                 active_o,
  output logic                 busy_o,
  output logic                 ready_o,
  output logic [CNT_W-1:0]     cnt_o,
  output logic [REG_IDX_W-1:0] cur_idx_o,
  output logic                 cur_wr_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_ACT, ST_REC} st_e;

  st_e                  st;
  logic [CNT_W-1:0]     wcnt, rcnt;
  logic                 pend, pend_wr;
  logic                 same_req, other_req;
  logic                 do_launch, l_wr;
  logic [REG_IDX_W-1:0] l_idx;

  assign active_o  = (st == ST_ACT);
  assign busy_o    = (st == ST_REC);
  assign ready_o   = active_o && (wcnt == rdy_dly_i);
  assign same_req  = start_i && hit_i && (idx_i == cur_idx_o);
  assign other_req = start_i && hit_i && (idx_i != cur_idx_o);

  always_comb begin
    do_launch = 1'b0;
    l_idx     = idx_i;
    l_wr      = wr_i;
    case (st)
      ST_IDLE: do_launch = start_i && hit_i;
      ST_REC: begin
        if (other_req) begin
          do_launch = 1'b1;
        end else if ((rcnt == CNT_W'(1)) && (pend || same_req)) begin
          do_launch = 1'b1;
          l_idx     = cur_idx_o;
          l_wr      = pend ? pend_wr : wr_i;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st        <= ST_IDLE;
      cnt_o     <= '0;
      wcnt      <= '0;
      rcnt      <= '0;
      cur_idx_o <= '0;
      cur_wr_o  <= 1'b0;
      pend      <= 1'b0;
      pend_wr   <= 1'b0;
    end else if (do_launch) begin
      st        <= ST_ACT;
      cnt_o     <= '0;
      wcnt      <= '0;
      cur_idx_o <= l_idx;
      cur_wr_o  <= l_wr;
      pend      <= 1'b0;
    end else begin
      case (st)
        ST_ACT: begin
          if (cnt_o != {CNT_W{1'b1}}) cnt_o <= cnt_o + 1'b1;
          if (ready_o) begin
            wcnt <= '0;
            if (last_i) begin
              if (b2b_dly_i == '0) begin
                st <= ST_IDLE;
              end else begin
                st   <= ST_REC;
                rcnt <= b2b_dly_i;
              end
            end
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        ST_REC: begin
          if (rcnt == CNT_W'(1)) begin
            st <= ST_IDLE;
          end else begin
            rcnt <= rcnt - 1'b1;
            if (same_req && !pend) begin
              pend    <= 1'b1;
              pend_wr <= wr_i;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cs_strobe_out.sv
module cs_strobe_out
  import cs_pkg::*;
(
  input  strobe_cfg_t          scfg_i [N_STB],
  input  logic                 active_i,
  input  logic [CNT_W-1:0]     cnt_i,
  input  logic [REG_IDX_W-1:0] idx_i,
  input  logic                 wr_i,
  input  logic [CNT_W-1:0]     asrt_i,
  input  logic [CNT_W-1:0]     deas_i,
  output logic [N_STB-1:0]     strobe_no
);
  logic in_window;
  assign in_window = (cnt_i >= asrt_i) && (cnt_i < deas_i);

  for (genvar s = 0; s < N_STB; s++) begin : g_out
    logic [1:0] q;
    logic       q_ok, on;
    assign q    = scfg_i[s].qual;
    assign q_ok = wr_i ? q[1] : q[0];
    assign on   = active_i && (scfg_i[s].sel == idx_i) && q_ok &&
                  (!scfg_i[s].sync || in_window);
    assign strobe_no[s] = !on;
  end
endmodule

// File: rtl/cs_strobe_gen.sv
module cs_strobe_gen
  import cs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [CFG_DW-1:0] cfg_wdata_i,
  input  logic              cyc_start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              last_i,
  output logic [N_STB-1:0]  strobe_no,
  output logic              ready_o,
  output logic              hit_o,
  output logic              busy_o,
  output logic              region_wide_o
);
  region_cfg_t          cfg  [N_REG];
  region_tim_t          tim  [N_REG];
  strobe_cfg_t          scfg [N_STB];
  logic [N_REG-1:0]     wide;
  logic                 m_hit, active, cur_wr;
  logic [REG_IDX_W-1:0] m_idx, cur_idx;
  logic [CNT_W-1:0]     cnt;
  region_tim_t          cur_tim;
  logic                 unused_low_addr;

  assign unused_low_addr = ^addr_i[GRAN_W-1:0];
  assign cur_tim         = tim[cur_idx];

  cs_region_file u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .addr_i (cfg_addr_i),
    .wdata_i(cfg_wdata_i),
    .cfg_o  (cfg),
    .tim_o  (tim),
    .wide_o (wide),
    .scfg_o (scfg)
  );

  cs_addr_match u_match (
    .cfg_i    (cfg),
    .addr_hi_i(addr_i[ADDR_W-1:GRAN_W]),
    .wr_i     (wr_i),
    .hit_o    (m_hit),
    .idx_o    (m_idx)
  );

  cs_cycle_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (cyc_start_i),
    .hit_i    (m_hit),
    .idx_i    (m_idx),
    .wr_i     (wr_i),
    .last_i   (last_i),
    .rdy_dly_i(cur_tim.rdy),
    .b2b_dly_i(cur_tim.b2b),
    .active_o (active),
    .busy_o   (busy_o),
    .ready_o  (ready_o),
    .cnt_o    (cnt),
    .cur_idx_o(cur_idx),
    .cur_wr_o (cur_wr)
  );

  cs_strobe_out u_stb (
    .scfg_i   (scfg),
    .active_i (active),
    .cnt_i    (cnt),
    .idx_i    (cur_idx),
    .wr_i     (cur_wr),
    .asrt_i   (cur_tim.asrt),
    .deas_i   (cur_tim.deas),
    .strobe_no(strobe_no)
  );

  assign hit_o         = active;
  assign region_wide_o = active && wide[cur_idx];
endmodule

// File: rtl/cs_strobe_gen_chk.sv
module cs_strobe_gen_chk
  import cs_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             last_i,
  input logic [N_STB-1:0] strobe_no,
  input logic             ready_o,
  input logic             hit_o,
  input logic             busy_o,
  input logic             region_wide_o
);
  AST_READY_IN_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> hit_o);  // R8

  AST_IDLE_STROBES_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (&strobe_no));  // R13

  AST_BUSY_NOT_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !hit_o);  // R10

  AST_LAST_ENDS_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && last_i) |=> !hit_o);  // R9

  AST_WIDTH_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && $past(hit_o) && !$past(ready_o)) |-> $stable(region_wide_o));  // R12

  AST_WIDE_NEEDS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    region_wide_o |-> hit_o);  // R12
endmodule

bind cs_strobe_gen cs_strobe_gen_chk u_chk (.*);

// File: tb/cs_strobe_gen_test.sv
`timescale 1ns/1ps
module cs_strobe_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        start = 1'b0;
  logic [31:0] addr = '0;
  logic        wr = 1'b0;
  logic        last = 1'b0;
  logic [7:0]  strobe_n;
  logic        ready, hit, busy, wide;

  int checks = 0;
  int errors = 0;

  int r_base[8], r_sz[8], r_rd[8], r_wr[8], r_wide[8];
  int r_as[8], r_de[8], r_rdy[8], r_b2b[8];
  int s_sel[8], s_q[8], s_sync[8];

  always #2.5 clk = ~clk;

  cs_strobe_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .cyc_start_i(start), .addr_i(addr), .wr_i(wr),
    .last_i(last), .strobe_no(strobe_n), .ready_o(ready), .hit_o(hit),
    .busy_o(busy), .region_wide_o(wide)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cfg_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_region(input int r, input int base, input int sz, input int rd,
                            input int wen, input int wd, input int as, input int de,
                            input int rdy, input int b2b);
    r_base[r] = base; r_sz[r] = sz; r_rd[r] = rd; r_wr[r] = wen; r_wide[r] = wd;
    r_as[r] = as; r_de[r] = de; r_rdy[r] = rdy; r_b2b[r] = b2b;
    cfg_write(5'(r * 2), (base << 16) | sz | (rd << 8) | (wen << 9) | (wd << 10));
    cfg_write(5'(r * 2 + 1), as | (de << 8) | (rdy << 16) | (b2b << 24));
  endtask

  task automatic set_strobe(input int s, input int sel, input int q, input int sy);
    s_sel[s] = sel; s_q[s] = q; s_sync[s] = sy;
    cfg_write(5'(16 + s), sel | (q << 4) | (sy << 8));
  endtask

  function automatic int exp_region(input int hi, input int w);
    for (int r = 0; r < 8; r++) begin
      if (((w != 0) ? r_wr[r] : r_rd[r]) != 0 && (((hi ^ r_base[r]) >> r_sz[r]) == 0))
        return r;
    end
    return -1;
  endfunction

  function automatic logic [7:0] exp_strobe(input int r, input int w, input int k);
    logic [7:0] v = 8'hff;
    for (int s = 0; s < 8; s++) begin
      bit qok = (w != 0) ? s_q[s][1] : s_q[s][0];
      bit win = (k >= r_as[r]) && (k < r_de[r]);
      if (s_sel[s] == r && qok && (s_sync[s] == 0 || win)) v[s] = 1'b0;
    end
    return v;
  endfunction

  // called at the falling edge of clock k = 0; returns just after the ending edge
  task automatic check_active(input int r, input int w, input int beats);
    int k = 0, wk = 0, left = beats;
    while (left > 0) begin
      last = (left == 1);
      check("R2 hit during cycle", hit, 1);
      check("R5 R6 R7 strobes", strobe_n, exp_strobe(r, w, k));
      check("R8 ready timing", ready, (wk == r_rdy[r]));
      check("R12 width", wide, r_wide[r]);
      if (wk == r_rdy[r]) begin left--; wk = 0; end
      else wk++;
      k++;
      @(posedge clk);
      if (left > 0) @(negedge clk);
    end
  endtask

  task automatic launch(input int hi, input int w);
    @(negedge clk);
    addr = (hi << 16) | 32'h0000_1234; wr = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_recovery(input int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      last = 1'b0;
      check("R10 busy held", busy, 1);
      check("R9 hit dropped", hit, 0);
      check("R9 strobes off", strobe_n, 8'hff);
    end
    @(negedge clk);
    last = 1'b0;
    check("R10 busy released", busy, 0);
    check("R9 idle after cycle", hit, 0);
  endtask

  task automatic run_cycle(input int hi, input int w, input int beats);
    int r = exp_region(hi, w);
    launch(hi, w);
    if (r < 0) begin
      for (int j = 0; j < 4; j++) begin
        check("R13 no hit", hit, 0);
        check("R13 no strobe", strobe_n, 8'hff);
        check("R13 no ready", ready, 0);
        @(negedge clk);
      end
    end else begin
      check_active(r, w, beats);
      wait_recovery(r_b2b[r]);
    end
  endtask

  initial begin
    int hi_list[9] = '{16'h000F, 16'h0010, 16'h0011, 16'h001F, 16'h0020,
                       16'h0021, 16'h0023, 16'h0024, 16'h8000};
    repeat (3) @(negedge clk);
    check("R1 strobes reset", strobe_n, 8'hff);
    check("R1 ready reset", ready, 0);
    check("R1 hit reset", hit, 0);
    check("R1 busy reset", busy, 0);
    check("R1 wide reset", wide, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: regions disabled after reset
    run_cycle(16'h0010, 0, 1);

    set_region(0, 16'h0010, 0, 1, 1, 1, 1, 3, 2, 3);
    set_region(1, 16'h0020, 2, 1, 0, 0, 0, 2, 0, 0);
    set_region(2, 16'h0000, 16, 1, 1, 0, 2, 4, 3, 2);
    set_strobe(0, 0, 3, 0);
    set_strobe(1, 0, 3, 1);
    set_strobe(2, 0, 1, 1);
    set_strobe(3, 0, 2, 0);
    set_strobe(4, 1, 3, 1);
    set_strobe(5, 2, 3, 0);
    set_strobe(6, 2, 2, 1);
    set_strobe(7, 1, 1, 0);

    // R2 R3 R4 sweep over addresses, access types, burst lengths
    foreach (hi_list[i])
      for (int w = 0; w < 2; w++)
        for (int b = 1; b <= 3; b++)
          run_cycle(hi_list[i], w, b);

    // R10: same-region start during recovery is held
    launch(16'h0010, 1);
    check_active(0, 1, 1);
    @(negedge clk);
    last = 1'b0;
    check("R10 busy sample 1", busy, 1);
    addr = 32'h0010_0000; wr = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R10 held busy", busy, 1);
    check("R10 held no strobe", strobe_n, 8'hff);
    @(negedge clk);
    check("R10 held busy 3", busy, 1);
    check("R10 held no hit", hit, 0);
    @(negedge clk);
    check("R10 deferred start", busy, 0);
    check_active(0, 0, 1);
    wait_recovery(3);

    // R11: other-region start during recovery begins at once
    launch(16'h0010, 0);
    check_active(0, 0, 2);
    @(negedge clk);
    last = 1'b0;
    check("R11 busy before", busy, 1);
    addr = 32'h0021_0000; wr = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R11 immediate start", busy, 0);
    check_active(1, 0, 1);
    wait_recovery(0);

    // R13: disable catch-all region, then miss
    set_region(2, 16'h0000, 16, 0, 0, 0, 2, 4, 3, 2);
    run_cycle(16'h0050, 0, 1);
    run_cycle(16'h0050, 1, 1);
    // R4: write to read-only region misses now
    run_cycle(16'h0021, 1, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule